// File: doc/BRIEF.md
# Grouped-Enable Boundary Register Segment

This block is one segment of a chip's boundary register. It sits in the I/O ring between the core and the output pads. The segment has no controller of its own. An external test access port controller supplies the decoded capture, shift and update strobes and a mode select. Output pins are arranged in logical groups, for example an address group and a data group. Each pin carries a drive cell and a receive cell, and the receive cell reads back the level actually present on the pad. Each group owns a single three-state control cell. A tester can therefore silence one bused group while another group drives stimulus, and can separate an open from a short by comparing what was driven with what was read back.

The serial path runs from `tdi` to `tdo`. Group 0 sits nearest `tdi`. Inside a group the order of cells, moving toward `tdo`, is the enable cell, then for each pin p in ascending order the drive cell followed by the receive cell. Cell index k counts from 0 at the `tdi` end. The enable cell of group g is at k = g*(2W+1), the drive cell of pin p of that group is at g*(2W+1)+1+2p, and its receive cell is at g*(2W+1)+2+2p. The chain length is G*(2W+1).

Each rising edge of `tck` selects one operation for the shift flops, named as states in the RTL:
- OP_CAPTURE is chosen when `capture_dr` is high, whatever `shift_dr` is.
- OP_SHIFT is chosen when only `shift_dr` is high.
- OP_HOLD is chosen when neither strobe is high.

The selection is made again on every edge, so any operation can follow any other. The update latches are a separate stage. They load from the shift flops on a falling edge of `tck` when `update_dr` is high.

Top module: `bscan_ring`

## Requirements
- R1: While `trst_n` is low, every update latch and every shift flop is 0. As a result, with `test_mode` high all `pad_oe` bits are 0, all `pad_out` bits are 0, and `tdo` is 0.
- R2: With `test_mode` low, `pad_out` equals `core_data` and every `pad_oe` bit of group g equals `core_oe[g]`.
- R3: With `test_mode` high, `pad_out[i]` equals the drive update latch of pin i, and every `pad_oe` bit of group g equals that group's enable update latch, where 1 means drive.
- R4: Update latches change only on a falling `tck` edge with `update_dr` high. Shifting or capturing without an update leaves `pad_out` and `pad_oe` unchanged.
- R5: In OP_SHIFT every cell moves one place toward `tdo`, `tdi` enters cell 0, and `tdo` shows the last cell. Shifting in L new bits therefore brings out the previous L cell values, cell L-1 first.
- R6: In OP_CAPTURE each drive cell loads its `core_data` bit, each enable cell loads its `core_oe` bit, and each receive cell loads its `pad_in` bit.
- R7: Each group's enable is independent of the others. Any combination of enabled and disabled groups can be applied, and all pins of one group always share one `pad_oe` value.
- R8: A capture with `test_mode` low leaves the pads following the core, and it still records the pad levels in the receive cells.
- R9: In OP_HOLD the shift flops keep their contents. When `capture_dr` and `shift_dr` are both high, capture takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Decoded capture strobe from the controller |
| shift_dr | input | 1 | Decoded shift strobe from the controller |
| update_dr | input | 1 | Decoded update strobe from the controller |
| test_mode | input | 1 | 1: update latches drive the pads; 0: core drives the pads |
| core_data | input | GROUPS*PINS_PER_GROUP | Core output data per pin |
| core_oe | input | GROUPS | Core output enable per group |
| pad_in | input | GROUPS*PINS_PER_GROUP | Level observed on each pad |
| pad_out | output | GROUPS*PINS_PER_GROUP | Data to each pad driver |
| pad_oe | output | GROUPS*PINS_PER_GROUP | Enable to each pad driver |
| tdo | output | 1 | Serial data out |

## Verification
The bench builds the segment with two groups of three pins, which gives a 14-cell chain. At that size every enable combination can be swept against every 6-bit drive pattern through a full shift, update and check sequence. The pass-through path is swept exhaustively over data and enables. For readback, the bench models an external bus that the pads override only where their group is enabled. This makes the receive cells show driven values on enabled groups and external values on disabled ones.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_e;

    // Capture outranks shift; neither strobe means hold.
    function automatic cell_op_e pick_op(input logic cap, input logic shf);
        if (cap)      return OP_CAPTURE;
        else if (shf) return OP_SHIFT;
        else          return OP_HOLD;
    endfunction

    function automatic int cells_per_group(input int pins);
        return 2 * pins + 1;
    endfunction

endpackage

// File: rtl/bsr_group.sv
module bsr_group
    import bsr_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         cap,
    input  logic         shf,
    input  logic         upd,
    input  logic         si,
    input  logic [W-1:0] core_data,
    input  logic         core_oe,
    input  logic [W-1:0] pad_in,
    output logic         so,
    output logic [W-1:0] drv_q,
    output logic         oe_q
);
    localparam int N = cells_per_group(W);

    logic [N-1:0] sr;
    logic [N-1:0] cap_vec;
    logic [W-1:0] drv_sr;
    cell_op_e     op;

    always_comb begin
        cap_vec[0] = core_oe;
        for (int p = 0; p < W; p++) begin
            cap_vec[1 + 2*p] = core_data[p];
            cap_vec[2 + 2*p] = pad_in[p];
            drv_sr[p]        = sr[1 + 2*p];
        end
    end

    always_comb op = pick_op(cap, shf);

    // Shift/capture stage, rising edge.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= '0;
        end else begin
            unique case (op)
                OP_CAPTURE: sr <= cap_vec;
                OP_SHIFT:   sr <= {sr[N-2:0], si};
                OP_HOLD:    sr <= sr;
            endcase
        end
    end

    // Update stage, falling edge; reset disables the group.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            oe_q  <= 1'b0;
            drv_q <= '0;
        end else if (upd) begin
            oe_q  <= sr[0];
            drv_q <= drv_sr;
        end
    end

    assign so = sr[N-1];

    // R1
    rst_clear_chk: assert property (@(posedge tck)
        !trst_n |-> (oe_q == 1'b0 && drv_q == '0 && sr == '0));

    // R5
    shift_in_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (shf && !cap) |=> (sr[0] == $past(si) && sr[N-1] == $past(sr[N-2])));

    // R6
    capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        cap |=> (sr[0] == $past(core_oe) && sr[1] == $past(core_data[0])
                 && sr[2] == $past(pad_in[0])));

    // R9
    hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!cap && !shf) |=> $stable(sr));

    // R4
    latch_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
        !upd |=> ($stable(oe_q) && $stable(drv_q)));

endmodule

// File: rtl/bscan_ring.sv
module bscan_ring
    import bsr_pkg::*;
#(
    parameter int GROUPS         = 2,
    parameter int PINS_PER_GROUP = 3
) (
    input  logic                               tck,
    input  logic                               trst_n,
    input  logic                               tdi,
    input  logic                               capture_dr,
    input  logic                               shift_dr,
    input  logic                               update_dr,
    input  logic                               test_mode,
    input  logic [GROUPS*PINS_PER_GROUP-1:0]   core_data,
    input  logic [GROUPS-1:0]                  core_oe,
    input  logic [GROUPS*PINS_PER_GROUP-1:0]   pad_in,
    output logic [GROUPS*PINS_PER_GROUP-1:0]   pad_out,
    output logic [GROUPS*PINS_PER_GROUP-1:0]   pad_oe,
    output logic                               tdo
);
    localparam int W = PINS_PER_GROUP;

    logic [GROUPS:0] link;
    assign link[0] = tdi;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [W-1:0] drv_q;
        logic         oe_q;

        bsr_group #(.W(W)) u_grp (
            .tck       (tck),
            .trst_n    (trst_n),
            .cap       (capture_dr),
            .shf       (shift_dr),
            .upd       (update_dr),
            .si        (link[g]),
            .core_data (core_data[g*W +: W]),
            .core_oe   (core_oe[g]),
            .pad_in    (pad_in[g*W +: W]),
            .so        (link[g+1]),
            .drv_q     (drv_q),
            .oe_q      (oe_q)
        );

        assign pad_out[g*W +: W] = test_mode ? drv_q : core_data[g*W +: W];
        assign pad_oe[g*W +: W]  = {W{test_mode ? oe_q : core_oe[g]}};

        // R7
        grp_oe_uniform_chk: assert property (@(posedge tck) disable iff (!trst_n)
            ($countones(pad_oe[g*W +: W]) == 0 || $countones(pad_oe[g*W +: W]) == W));
    end

    assign tdo = link[GROUPS];

endmodule

// File: tb/bscan_ring_tb.sv
module bscan_ring_tb;
    localparam int CLK_PERIOD = 10;
    localparam int G = 2;
    localparam int W = 3;
    localparam int NP = G * W;
    localparam int CPG = 2 * W + 1;
    localparam int L = G * CPG;

    logic          tck = 1'b0;
    logic          trst_n, tdi, capture_dr, shift_dr, update_dr, test_mode;
    logic [NP-1:0] core_data, pad_in, pad_out, pad_oe, ext_bus;
    logic [G-1:0]  core_oe;
    logic          tdo;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) tck = ~tck;

    // External bus: pads override it only where enabled.
    for (genvar i = 0; i < NP; i++) begin : g_bus
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext_bus[i];
    end

    bscan_ring #(.GROUPS(G), .PINS_PER_GROUP(W)) u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .test_mode(test_mode),
        .core_data(core_data), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .tdo(tdo)
    );

    function automatic int en_idx(int g);         return g * CPG;           endfunction
    function automatic int drv_idx(int g, int p); return g * CPG + 1 + 2*p; endfunction
    function automatic int rx_idx(int g, int p);  return g * CPG + 2 + 2*p; endfunction

    function automatic logic [NP-1:0] expand(logic [G-1:0] e);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = e[i / W];
        return r;
    endfunction

    function automatic logic [L-1:0] make_vec(logic [G-1:0] e, logic [NP-1:0] d);
        logic [L-1:0] v;
        for (int g = 0; g < G; g++) begin
            v[en_idx(g)] = e[g];
            for (int p = 0; p < W; p++) begin
                v[drv_idx(g, p)] = d[g*W+p];
                v[rx_idx(g, p)]  = ~d[g*W+p];
            end
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck); #1;
    endtask

    task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
        for (int j = 0; j < L; j++) begin
            shift_dr = 1'b1;
            tdi = vin[L-1-j];
            vout[L-1-j] = tdo;
            step();
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] prev, v, got, expv;
        logic [NP-1:0] cur_d, dd;
        logic [G-1:0]  cur_e;

        trst_n = 1'b0; tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; test_mode = 1'b1; core_data = '1; core_oe = '1;
        ext_bus = '0;
        step(); step();
        // R1: reset state with test mode selected
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 pad_out", 32'(pad_out), 0);
        chk("R1 tdo", 32'(tdo), 0);
        trst_n = 1'b1;
        step();

        // R2: pass-through sweep
        test_mode = 1'b0;
        for (int e = 0; e < (1 << G); e++) begin
            for (int d = 0; d < (1 << NP); d++) begin
                core_oe = G'(e); core_data = NP'(d);
                #1;
                chk("R2 pad_out", 32'(pad_out), 32'(d));
                chk("R2 pad_oe", 32'(pad_oe), 32'(expand(G'(e))));
            end
        end

        // R3 R4 R5 R7: shift, hold pads, update, check per group
        test_mode = 1'b1;
        core_data = '0; core_oe = '0;
        step();
        prev = '0; cur_d = '0; cur_e = '0;
        for (int e = 0; e < (1 << G); e++) begin
            for (int d = 0; d < (1 << NP); d++) begin
                v = make_vec(G'(e), NP'(d));
                shift_vec(v, got);
                chk("R5 shift-out", 32'(got), 32'(prev));
                chk("R4 pad_out before update", 32'(pad_out), 32'(cur_d));
                chk("R4 pad_oe before update", 32'(pad_oe), 32'(expand(cur_e)));
                do_update();
                chk("R3 pad_out", 32'(pad_out), 32'(d));
                chk("R7 pad_oe per group", 32'(pad_oe), 32'(expand(G'(e))));
                prev = v; cur_d = NP'(d); cur_e = G'(e);
            end
        end

        // R9: hold keeps contents
        v = make_vec(2'b01, 6'b101100);
        shift_vec(v, got);
        do_update();
        repeat (5) step();
        shift_vec(v, got);
        chk("R9 hold", 32'(got), 32'(v));
        cur_d = 6'b101100; cur_e = 2'b01;

        // R6 R4: capture readback with mixed enables
        for (int e = 0; e < (1 << G); e++) begin
            for (int x = 0; x < (1 << NP); x += 9) begin
                dd = NP'(x) ^ 6'h2A;
                v = make_vec(G'(e), dd);
                shift_vec(v, got);
                do_update();
                ext_bus = NP'(x);
                core_data = ~NP'(x);
                core_oe = G'(e) ^ 2'b01;
                do_capture();
                chk("R4 pad_out after capture", 32'(pad_out), 32'(dd));
                for (int g = 0; g < G; g++) begin
                    expv[en_idx(g)] = core_oe[g];
                    for (int p = 0; p < W; p++) begin
                        expv[drv_idx(g, p)] = core_data[g*W+p];
                        expv[rx_idx(g, p)]  = e[g] ? dd[g*W+p] : ext_bus[g*W+p];
                    end
                end
                shift_vec('0, got);
                chk("R6 capture readback", 32'(got), 32'(expv));
            end
        end

        // R8: sample while core owns the pads
        test_mode = 1'b0;
        core_data = 6'b110010; core_oe = 2'b10; ext_bus = 6'b010101;
        #1;
        do_capture();
        chk("R8 pad_out undisturbed", 32'(pad_out), 32'(6'b110010));
        chk("R8 pad_oe undisturbed", 32'(pad_oe), 32'(expand(2'b10)));
        for (int g = 0; g < G; g++) begin
            expv[en_idx(g)] = core_oe[g];
            for (int p = 0; p < W; p++) begin
                expv[drv_idx(g, p)] = core_data[g*W+p];
                expv[rx_idx(g, p)]  = core_oe[g] ? core_data[g*W+p] : ext_bus[g*W+p];
            end
        end
        shift_vec('0, got);
        chk("R8 sample readback", 32'(got), 32'(expv));

        // R9: capture outranks shift
        test_mode = 1'b1;
        shift_vec('1, got);
        v = make_vec(2'b00, 6'b000000);
        shift_vec(v, got);
        do_update();
        shift_vec('1, got);
        core_data = '0; core_oe = '0; ext_bus = '0;
        capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        step();
        capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
        shift_vec('0, got);
        chk("R9 capture priority", 32'(got), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule